// File: doc/BRIEF.md
# Two-Wire Preset-ROM Slave

This block sits on a two-wire serial bus as a read-only memory target that holds 256 preset bytes. A bus master toggles the clock and data lines. The block samples both lines on its own system clock and finds bus events by comparing each sample with the one before it. It answers by pulling the data line low through an open-drain style output.

A transaction opens with a START condition. The master then sends a command byte, which the block acknowledges. The master sends an address byte, which the block acknowledges as well. During the address byte of a read command, the block shifts out the byte that the previous transaction loaded, MSB first, and reads the byte at the new address into its output shift register ready for the next time. No part of the memory can be written. The block does not match a device address and does not hold the clock low.

The block moves no data stream, so it has no valid/ready interface. All pins are plain levels. The master sees the wired-AND of its own data drive and the block's drive, and it has to accept whatever the block puts on the line.

Top module: `serial_rom_slave`

## Requirements
- R1: While reset is asserted, `sda_drive_low` is 0 and both sampled lines are taken as high (idle bus).
- R2: A master data fall while the clock is high in two consecutive samples is a START. START sets the bit counter to 1, clears the command register and releases the drive. A master data rise while the clock is high is a STOP. STOP releases the drive and leaves the counter unchanged.
- R3: With the bit counter at 0 and no acknowledge pending, rising clock edges are ignored and the drive stays released.
- R4: Counter values 1 to 8 shift master data into the command register MSB-first, one bit per rising clock edge. After the eighth bit an acknowledge is pending. The next rising edge drives the line low. Command bit 0 = 1 selects read, for example command 0xA1.
- R5: The next 8 accepted rising edges shift in the word address. After the last of them, the output shift register loads the ROM byte at that address, an acknowledge is pending that the next rising edge serves, and the counter returns to 0.
- R6: For a read command, each address-phase rising edge sets `sda_drive_low` to the inverse of the output shift register's MSB, then shifts that register left. For a write command the drive stays released.
- R7: Once set, the drive stays low until the next falling clock edge, START or STOP releases it.
- R8: A rising clock edge at which the master data sample differs from the previous sample discards the bit. Nothing changes.
- R9: ROM contents: bytes 0x00 to 0x06 are 0x80, 0x08, 0x04, 0x0D, 0x0A, 0x01, 0x40. Byte 0x3E is 0x12, 0x3F is 0xD0, 0x7E is 0x64 and 0x7F is 0xF4. Every other byte is 0x00.
- R10: A change on `scl_in` or `sda_in` affects `sda_drive_low` exactly 3 clock cycles later: two synchroniser stages plus one state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level from the master |
| sda_in | input | 1 | Master's own data drive level (1 = released) |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Every result the block produces shows up on `sda_drive_low` in the third clock cycle after the input change that causes it. The bench's reference model therefore reads its clock and data history three samples back. It compares its own drive value against the block's on every falling clock edge. The directed checks read the wired-AND line late in each clock-high phase, well past those three cycles, so the data they see has settled. One check times the 3-cycle edge of an acknowledge explicitly.

// File: rtl/serrom_pkg.sv
package serrom_pkg;

  localparam int PRESET_BYTES = 256;

  // Sparse preset table; unlisted locations read as zero.
  function automatic logic [7:0] preset_byte(input int loc);
    logic [7:0] v;
    case (loc)
      0:       v = 8'h80;
      1:       v = 8'h08;
      2:       v = 8'h04;
      3:       v = 8'h0D;
      4:       v = 8'h0A;
      5:       v = 8'h01;
      6:       v = 8'h40;
      62:      v = 8'h12;
      63:      v = 8'hD0;
      126:     v = 8'h64;
      127:     v = 8'hF4;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/line_sampler.sv
module line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond,
  output logic sda_now,
  output logic sda_steady
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev, scl_now;

  // Idle bus reads high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[LAST-1:0], scl_in};
      sda_sync <= {sda_sync[LAST-1:0], sda_in};
      scl_prev <= scl_sync[LAST];
      sda_prev <= sda_sync[LAST];
    end
  end

  assign scl_now    = scl_sync[LAST];
  assign sda_now    = sda_sync[LAST];
  assign scl_rise   = ~scl_prev & scl_now;
  assign scl_fall   = scl_prev & ~scl_now;
  assign start_cond = scl_prev & scl_now & sda_prev & ~sda_now;
  assign stop_cond  = scl_prev & scl_now & ~sda_prev & sda_now;
  assign sda_steady = (sda_prev == sda_now);

endmodule

// File: rtl/preset_rom.sv
module preset_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  always_comb data = DATA_W'(serrom_pkg::preset_byte(int'(addr)));
endmodule

// File: rtl/bit_sequencer.sv
module bit_sequencer #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cond,
  input  logic              stop_cond,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_now,
  input  logic              sda_steady,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              sda_drive_low
);
  localparam int LAST_TICK = CMD_W + ADDR_W;
  localparam int TICK_W    = $clog2(LAST_TICK + 2);

  logic [TICK_W-1:0] tick_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              ack_q, drive_q;
  logic              armed;

  assign armed         = (tick_q != '0) || ack_q;
  assign rom_addr      = {addr_q[ADDR_W-2:0], sda_now};
  assign sda_drive_low = drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      ack_q   <= 1'b0;
      drive_q <= 1'b0;
    end else if (start_cond) begin
      tick_q  <= TICK_W'(1);
      cmd_q   <= '0;
      drive_q <= 1'b0;
    end else if (stop_cond || scl_fall) begin
      drive_q <= 1'b0;
    end else if (scl_rise && armed) begin
      if (ack_q) begin
        drive_q <= 1'b1;
        ack_q   <= 1'b0;
      end else if (sda_steady) begin
        if (tick_q <= TICK_W'(CMD_W)) begin
          cmd_q  <= {cmd_q[CMD_W-2:0], sda_now};
          tick_q <= tick_q + TICK_W'(1);
          if (tick_q == TICK_W'(CMD_W)) ack_q <= 1'b1;
        end else begin
          addr_q  <= rom_addr;
          drive_q <= cmd_q[0] & ~data_q[DATA_W-1];
          if (tick_q == TICK_W'(LAST_TICK)) begin
            data_q <= rom_data;
            ack_q  <= 1'b1;
            tick_q <= '0;
          end else begin
            data_q <= data_q << 1;
            tick_q <= tick_q + TICK_W'(1);
          end
        end
      end
    end
  end

  // START re-arms the sequencer from any state
  assert_start_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_cond |=> (tick_q == TICK_W'(1)) && (cmd_q == '0) && !drive_q);

  // STOP releases the line
  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cond |=> !drive_q);

  // idle sequencer keeps its registers
  assert_idle_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q == '0 && !ack_q && !start_cond) |=>
      (tick_q == '0) && $stable(cmd_q) && $stable(addr_q) && $stable(data_q));

  // a pending acknowledge is served on the next rising edge
  assert_ack_serve_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && ack_q && !start_cond) |=> drive_q && !ack_q);

  // counter never passes the end of the address byte
  assert_tick_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= TICK_W'(LAST_TICK));

  // a falling clock always frees the line
  assert_fall_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !start_cond) |=> !drive_q);

  // an unstable data sample at a rising edge changes nothing
  assert_glitch_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !ack_q && !sda_steady && tick_q != '0) |=>
      $stable(tick_q) && $stable(cmd_q) && $stable(addr_q) && $stable(data_q) && $stable(drive_q));

endmodule

// File: rtl/serial_rom_slave.sv
module serial_rom_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_drive_low
);
  logic scl_rise, scl_fall, start_cond, stop_cond, sda_now, sda_steady;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;

  line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sample (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_cond(start_cond), .stop_cond(stop_cond),
    .sda_now(sda_now), .sda_steady(sda_steady)
  );

  preset_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .addr(rom_addr), .data(rom_data)
  );

  bit_sequencer #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_cond(start_cond), .stop_cond(stop_cond),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_now(sda_now), .sda_steady(sda_steady),
    .rom_addr(rom_addr), .rom_data(rom_data),
    .sda_drive_low(sda_drive_low)
  );

  // reset leaves the line released (R1)
  assert_reset_release_R1: assert property (@(posedge clk)
    !rst_n |=> !sda_drive_low);

endmodule

// File: tb/sim_serial_rom_slave.sv
module sim_serial_rom_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic drv;
  logic line;

  always #5 clk = ~clk;

  serial_rom_slave u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_m), .sda_drive_low(drv));

  assign line = sda_m & ~drv;

  int cyc_vec = 0, cyc_bad = 0, chk_vec = 0, chk_bad = 0, wd_bad = 0, ncyc = 0;

  function automatic int exp_byte(input int a);
    case (a)
      0: return 'h80; 1: return 'h08; 2: return 'h04; 3: return 'h0D;
      4: return 'h0A; 5: return 'h01; 6: return 'h40;
      'h3E: return 'h12; 'h3F: return 'hD0; 'h7E: return 'h64; 'h7F: return 'hF4;
      default: return 0;
    endcase
  endfunction

  // behavioural reference model, inputs seen three samples late (R10)
  bit [3:0] h_scl = 4'hF, h_sda = 4'hF;
  int  m_tick = 0, m_cmd = 0, m_addr = 0, m_data = 0;
  bit  m_ack = 0, m_drv = 0;

  always @(posedge clk) begin
    ncyc++;
    if (!rst_n) begin
      h_scl = 4'hF; h_sda = 4'hF;
      m_tick = 0; m_cmd = 0; m_addr = 0; m_data = 0; m_ack = 0; m_drv = 0;
    end else begin
      bit cp, cc, dp, dc;
      h_scl = {h_scl[2:0], scl_m};
      h_sda = {h_sda[2:0], sda_m};
      cc = h_scl[2]; cp = h_scl[3]; dc = h_sda[2]; dp = h_sda[3];
      if (cp && cc && dp != dc) begin
        if (!dc) begin m_tick = 1; m_cmd = 0; end
        m_drv = 0;
      end else if (cp && !cc) begin
        m_drv = 0;
      end else if (!cp && cc && (m_tick != 0 || m_ack)) begin
        if (m_ack) begin
          m_drv = 1; m_ack = 0;
        end else if (dp == dc) begin
          if (m_tick <= 8) begin
            m_cmd = ((m_cmd << 1) | int'(dc)) & 'hFF;
            m_tick++;
            if (m_tick == 9) m_ack = 1;
          end else begin
            m_drv  = (m_cmd % 2 == 1) && ((m_data & 'h80) == 0);
            m_addr = ((m_addr << 1) | int'(dc)) & 'hFF;
            m_data = (m_data << 1) & 'hFF;
            m_tick++;
            if (m_tick == 17) begin
              m_data = exp_byte(m_addr); m_ack = 1; m_tick = 0;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (ncyc >= 1) begin
      cyc_vec++;
      if (drv !== m_drv) begin
        cyc_bad++;
        $display("FAIL R10 model compare at cycle %0d: actual=%0b expected=%0b", ncyc, drv, m_drv);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    chk_vec++;
    if (act !== exp) begin
      chk_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic got);
    sda_m = b; wait_cyc(5);
    scl_m = 1'b1; wait_cyc(5);
    got = line;
    scl_m = 1'b0; wait_cyc(5);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) begin
      logic g;
      bit_cycle(v[i], g);
      seen[i] = g;
    end
  endtask

  task automatic start_c();
    sda_m = 1'b1; wait_cyc(5);
    scl_m = 1'b1; wait_cyc(5);
    sda_m = 1'b0; wait_cyc(5);
    scl_m = 1'b0; wait_cyc(5);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wait_cyc(5);
    scl_m = 1'b1; wait_cyc(5);
    sda_m = 1'b1; wait_cyc(5);
    scl_m = 1'b0; wait_cyc(5);
  endtask

  task automatic transact(input logic [7:0] cmd, input logic [7:0] adr,
                          output logic [7:0] seen, output logic a1, output logic a2);
    logic [7:0] cs;
    start_c();
    send_byte(cmd, cs);
    bit_cycle(1'b1, a1);
    send_byte(adr, seen);
    bit_cycle(1'b1, a2);
    stop_c();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==",
             cyc_vec + chk_vec, cyc_bad + chk_bad + wd_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_bad = 1;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic g, a1, a2;
    logic [7:0] seen;
    int addrs [5] = '{'h00, 'h3F, 'h7E, 'h10, 'h05};

    wait_cyc(4);
    chk("R1 drive during reset", drv, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk("R1 drive after reset", drv, 0);
    scl_m = 1'b0; wait_cyc(5);

    // R3: clocking without START gets no response
    for (int i = 0; i < 10; i++) begin
      bit_cycle(logic'(i % 3 == 0), g);
      chk("R3 idle line follows master", g, int'(i % 3 == 0));
    end

    // R4/R5/R6: first read, shift register still zero from reset
    transact(8'hA1, 8'h3E, seen, a1, a2);
    chk("R4 command ack", a1, 0);
    chk("R6 read drives inverted zero data", seen, 'h00);
    chk("R5 address ack", a2, 0);

    // R9: byte at 0x3E appears in next read's address phase
    transact(8'hA1, 8'hFF, seen, a1, a2);
    chk("R9 byte 0x3E", seen, 'h12);

    foreach (addrs[k]) begin
      transact(8'hA1, 8'(addrs[k]), seen, a1, a2);
      transact(8'hA1, 8'hFF, seen, a1, a2);
      chk($sformatf("R9 byte %0h", addrs[k]), seen, exp_byte(addrs[k]));
    end

    // R6: write command leaves the line released but still loads data
    transact(8'hA0, 8'h3E, seen, a1, a2);
    chk("R6 write address phase released", seen, 'h3E);
    chk("R5 write address ack", a2, 0);
    transact(8'hA1, 8'hFF, seen, a1, a2);
    chk("R5 write loaded data", seen, 'h12);

    // R7 + R3: after address ack, drive freed on fall and later edges ignored
    start_c();
    send_byte(8'hA1, seen);
    bit_cycle(1'b1, a1);
    send_byte(8'h00, seen);
    bit_cycle(1'b1, a2);
    chk("R7 drive released after ack fall", drv, 0);
    bit_cycle(1'b1, g);
    chk("R3 edge after transaction ignored", g, 1);
    stop_c();

    // R8: sda changes with the rising clock, bit discarded
    start_c();
    sda_m = 1'b0; wait_cyc(5);
    sda_m = 1'b1; scl_m = 1'b1; wait_cyc(5);
    scl_m = 1'b0; wait_cyc(5);
    send_byte(8'hA1, seen);
    chk("R8 command bits undisturbed", seen, 'hA1);
    bit_cycle(1'b1, a1);
    chk("R8 ack after eight valid bits", a1, 0);
    stop_c();

    // R2: restart mid-command, then STOP during ack, R10 timing
    start_c();
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, g);
    start_c();
    send_byte(8'hA1, seen);
    sda_m = 1'b0; wait_cyc(5);
    scl_m = 1'b1;
    wait_cyc(2);
    chk("R10 drive not yet set after 2 cycles", drv, 0);
    wait_cyc(1);
    chk("R10 drive set at 3rd cycle", drv, 1);
    chk("R2 restarted command acked", drv, 1);
    wait_cyc(3);
    sda_m = 1'b1; wait_cyc(5);
    chk("R2 STOP releases drive", drv, 0);
    chk("R7 STOP release line high", line, 1);
    scl_m = 1'b0; wait_cyc(5);

    finish_run();
  end
endmodule